// File: doc/BRIEF.md
# Serial-Entry Memory Programming Port

This block gives an external programmer a way to write and check the contents of a 2K-byte on-chip program memory over a handful of shared pins. It watches the device reset input, which is sampled on the crystal clock. A reset is counted only after the input has stayed high for a full qualification window. Once the pin is released, the block reads a 10-bit key from that same pin, one bit per clock and least significant bit first. If the key matches, the block enters the programming state. Any other pattern leaves the device in normal operation.

In the programming state, one 8-bit address port carries both halves of an 11-bit address, and a select pin says which half is on the port. A mode pin picks between two operations. In verify, the addressed byte is driven onto the data port. In program, the data port is an input, and each falling edge of the mode pin issues exactly one write. The memory array sits outside the block and is reached through a synchronous interface with one read or write per cycle.

Top module: `serial_prog_if`

## Requirements
- R1: While `rst_n` is low, `prog_active`, `data_oe`, `mem_rd` and `mem_wr` are all 0.
- R2: A reset is qualified only after `rst_pin` has been sampled high on RST_CYC consecutive clock edges (default 24). A high run one sample shorter, followed by a key, leaves `prog_active` at 0.
- R3: After a qualified reset, the first low sample of `rst_pin` is the release and is not a key bit. The next KEY_W samples (default 10) form the key, with the first sample as bit 0. If the key equals ENTRY_KEY (default 10'h2B5), `prog_active` is 1 from the edge that samples the last key bit.
- R4: If the received key differs from ENTRY_KEY in any bit, `prog_active` stays 0.
- R5: In the programming state, each edge with `asel`=0 loads `addr_port` into address bits [7:0]. Each edge with `asel`=1 loads `addr_port[2:0]` into address bits [10:8]; port bits [7:3] are ignored. The address is driven on `mem_addr` in the cycle after it is loaded.
- R6: In the programming state with `mode`=1, `mem_rd` is 1. The edge after a `mode`=1 sample sets `data_oe` to 1, and `data_out` then shows the byte read at the address held at that edge.
- R7: In the programming state, a `mode` sample of 0 that follows a sample of 1 issues one `mem_wr` pulse lasting one cycle, in the next cycle. That pulse carries the `data_in` value and the address held at that edge, even if the address registers change during the pulse. While `mode` stays 0, no further write is issued.
- R8: After an edge that samples `mode`=0, `data_oe` is 0 and `data_out` is 0.
- R9: In the programming state, a high run on `rst_pin` shorter than RST_CYC has no effect. A run of RST_CYC highs clears `prog_active` from the edge of the last high sample, and the key must then be sent again.
- R10: Outside the programming state, `mem_rd`, `mem_wr` and `data_oe` stay 0 whatever `mode`, `asel` and the ports do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock; all pins are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low block reset |
| rst_pin | input | 1 | Device reset pin, also the serial key input |
| asel | input | 1 | Address half select: 0 low byte, 1 high bits |
| mode | input | 1 | 1 verify (read out), 0 program (write in) |
| addr_port | input | 8 | Shared address port |
| data_in | input | 8 | Data port input value |
| data_out | output | 8 | Data port output value |
| data_oe | output | 1 | Data port output enable |
| mem_addr | output | 11 | Memory address |
| mem_rd | output | 1 | Memory read request, data returned one cycle later |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |
| prog_active | output | 1 | Programming state is active |

## Verification
The bench probes the reset window at its edge: 23 highs followed by a correct key must not unlock the block. A counter that is off by one would unlock it. Keys wrong in the first bit and in the last bit catch a design that shifts in the wrong direction or compares only part of the pattern. Writes are checked with the address port changed during the strobe cycle and with `mode` held low afterwards. A design that used the live address, or that wrote on a level rather than an edge, would corrupt a second location or write more than once. Short reset glitches in the programming state must leave it active, while a full window must drop it.

// File: rtl/spif_pkg.sv
package spif_pkg;

   typedef enum logic [1:0] {
      ST_RUN   = 2'd0,
      ST_HELD  = 2'd1,
      ST_SHIFT = 2'd2,
      ST_PROG  = 2'd3
   } spif_state_e;

endpackage

// File: rtl/spif_rst_qual.sv
module spif_rst_qual #(
   parameter int RST_CYC = 24
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic hit
);
   localparam int CW = $clog2(RST_CYC + 1);

   if (RST_CYC < 2) begin : g_bad_cyc
      $error("spif_rst_qual: RST_CYC must be at least 2");
   end

   logic [CW-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (!pin) begin
         run_q <= '0;
      end else if (run_q != CW'(RST_CYC)) begin
         run_q <= run_q + 1'b1;
      end
   end

   // this edge is the RST_CYC-th (or later) consecutive high sample
   assign hit = pin && (run_q >= CW'(RST_CYC - 1));

   AST_HIT_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> $past(pin)) else $error("qualified reset without prior high"); // R2

endmodule

// File: rtl/spif_entry_fsm.sv
module spif_entry_fsm
   import spif_pkg::*;
#(
   parameter int              KEY_W     = 10,
   parameter logic [KEY_W-1:0] ENTRY_KEY = 10'h2B5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic rst_hit,
   output logic prog_active
);
   localparam int BCW = $clog2(KEY_W);

   if (KEY_W < 2) begin : g_bad_key
      $error("spif_entry_fsm: KEY_W must be at least 2");
   end

   spif_state_e      state_q;
   logic [KEY_W-1:0] shreg_q;
   logic [BCW-1:0]   bit_q;
   logic [KEY_W-1:0] assembled;

   // LSB first: each new bit enters at the top and moves down
   assign assembled = {pin, shreg_q[KEY_W-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_RUN;
         shreg_q <= '0;
         bit_q   <= '0;
      end else if (rst_hit) begin
         state_q <= ST_HELD;
      end else begin
         unique case (state_q)
            ST_HELD: begin
               if (!pin) begin
                  state_q <= ST_SHIFT;
                  bit_q   <= '0;
               end
            end
            ST_SHIFT: begin
               shreg_q <= assembled;
               bit_q   <= bit_q + 1'b1;
               if (bit_q == BCW'(KEY_W - 1)) begin
                  state_q <= (assembled == ENTRY_KEY) ? ST_PROG : ST_RUN;
               end
            end
            default: state_q <= state_q;
         endcase
      end
   end

   assign prog_active = (state_q == ST_PROG);

   AST_PROG_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prog_active) |-> ($past(state_q) == ST_SHIFT)) else $error("entry not from key"); // R3

   AST_PROG_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(prog_active) |-> $past(rst_hit)) else $error("left programming without reset"); // R9

endmodule

// File: rtl/spif_addr_latch.sv
module spif_addr_latch #(
   parameter int ADDR_W = 11,
   parameter int PORT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog_active,
   input  logic              asel,
   input  logic [PORT_W-1:0] port,
   output logic [ADDR_W-1:0] addr
);
   localparam int HI_W = ADDR_W - PORT_W;

   if (ADDR_W <= PORT_W || ADDR_W > 2 * PORT_W) begin : g_bad_split
      $error("spif_addr_latch: ADDR_W must lie in (PORT_W, 2*PORT_W]");
   end

   logic [PORT_W-1:0] lo_q;
   logic [HI_W-1:0]   hi_q;
   logic [HI_W-1:0]   hi_src;

   if (HI_W == PORT_W) begin : g_hi_full
      assign hi_src = port;
   end else begin : g_hi_part
      logic unused_upper;
      assign hi_src       = port[HI_W-1:0];
      assign unused_upper = ^port[PORT_W-1:HI_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else if (prog_active) begin
         if (asel) hi_q <= hi_src;
         else      lo_q <= port;
      end
   end

   assign addr = {hi_q, lo_q};

   AST_LO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!prog_active || asel) |=> $stable(lo_q)) else $error("low half moved"); // R5

   AST_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!prog_active || !asel) |=> $stable(hi_q)) else $error("high half moved"); // R5

endmodule

// File: rtl/spif_access.sv
module spif_access #(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog_active,
   input  logic              mode,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data_in,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [DATA_W-1:0] data_out,
   output logic              data_oe
);
   logic              mode_q;
   logic              wr_q;
   logic              oe_q;
   logic              fall;
   logic [ADDR_W-1:0] wa_q;
   logic [DATA_W-1:0] wd_q;

   assign fall = prog_active && mode_q && !mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= 1'b0;
         wr_q   <= 1'b0;
         oe_q   <= 1'b0;
         wa_q   <= '0;
         wd_q   <= '0;
      end else begin
         mode_q <= mode;
         wr_q   <= fall;
         oe_q   <= prog_active && mode;
         if (fall) begin
            wa_q <= addr;
            wd_q <= data_in;
         end
      end
   end

   assign mem_rd    = prog_active && mode;
   assign mem_wr    = wr_q;
   assign mem_addr  = wr_q ? wa_q : addr;
   assign mem_wdata = wd_q;
   assign data_oe   = oe_q;
   assign data_out  = oe_q ? mem_rdata : '0;

   AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |=> !mem_wr) else $error("write strobe longer than a cycle"); // R7

   AST_WR_ONLY_PROG: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> $past(prog_active)) else $error("write outside programming"); // R10

   AST_OE_NEEDS_VERIFY: assert property (@(posedge clk) disable iff (!rst_n)
      data_oe |-> ($past(mode) && $past(prog_active))) else $error("output enabled in program mode"); // R8

endmodule

// File: rtl/serial_prog_if.sv
module serial_prog_if #(
   parameter int               ADDR_W    = 11,
   parameter int               PORT_W    = 8,
   parameter int               DATA_W    = 8,
   parameter int               RST_CYC   = 24,
   parameter int               KEY_W     = 10,
   parameter logic [KEY_W-1:0] ENTRY_KEY = 10'h2B5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rst_pin,
   input  logic              asel,
   input  logic              mode,
   input  logic [PORT_W-1:0] addr_port,
   input  logic [DATA_W-1:0] data_in,
   output logic [DATA_W-1:0] data_out,
   output logic              data_oe,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              prog_active
);
   logic              rst_hit;
   logic [ADDR_W-1:0] addr;

   spif_rst_qual #(.RST_CYC(RST_CYC)) u_qual (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (rst_pin),
      .hit   (rst_hit)
   );

   spif_entry_fsm #(.KEY_W(KEY_W), .ENTRY_KEY(ENTRY_KEY)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .pin         (rst_pin),
      .rst_hit     (rst_hit),
      .prog_active (prog_active)
   );

   spif_addr_latch #(.ADDR_W(ADDR_W), .PORT_W(PORT_W)) u_addr (
      .clk         (clk),
      .rst_n       (rst_n),
      .prog_active (prog_active),
      .asel        (asel),
      .port        (addr_port),
      .addr        (addr)
   );

   spif_access #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_acc (
      .clk         (clk),
      .rst_n       (rst_n),
      .prog_active (prog_active),
      .mode        (mode),
      .addr        (addr),
      .data_in     (data_in),
      .mem_rdata   (mem_rdata),
      .mem_addr    (mem_addr),
      .mem_rd      (mem_rd),
      .mem_wr      (mem_wr),
      .mem_wdata   (mem_wdata),
      .data_out    (data_out),
      .data_oe     (data_oe)
   );

   AST_IDLE_IN_RESET: assert property (@(posedge clk)
      !rst_n |-> (!prog_active && !mem_wr && !data_oe)) else $error("outputs active in reset"); // R1

endmodule

// File: tb/tb_serial_prog_if.sv
module tb_serial_prog_if;
   localparam logic [9:0] KEY = 10'h2B5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rst_pin = 1'b0;
   logic       asel = 1'b0;
   logic       mode = 1'b1;
   logic [7:0] addr_port = 8'h00;
   logic [7:0] data_in = 8'h00;
   logic [7:0] data_out;
   logic       data_oe;
   logic [10:0] mem_addr;
   logic       mem_rd;
   logic       mem_wr;
   logic [7:0] mem_wdata;
   logic [7:0] mem_rdata;
   logic       prog_active;

   int total = 0;
   int bad = 0;
   int wr_cnt = 0;
   bit done = 0;

   logic [7:0] mem [2048];

   always #2 clk = ~clk;

   serial_prog_if dut (
      .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin), .asel(asel), .mode(mode),
      .addr_port(addr_port), .data_in(data_in), .data_out(data_out),
      .data_oe(data_oe), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .prog_active(prog_active)
   );

   function automatic logic [7:0] fill(input int a);
      return 8'(a * 13 + 5);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 2048; i++) mem[i] <= fill(i);
         mem_rdata <= 8'h00;
      end else begin
         if (mem_wr) begin
            mem[mem_addr] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
         end
         if (mem_rd) mem_rdata <= mem[mem_addr];
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   // highs: consecutive high samples; then release, then key LSB first
   task automatic send_entry(input int highs, input logic [9:0] key);
      for (int i = 0; i < highs; i++) begin
         @(negedge clk); rst_pin = 1'b1;
      end
      @(negedge clk); rst_pin = 1'b0;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk); rst_pin = key[i];
      end
      @(negedge clk); rst_pin = 1'b0;
   endtask

   // leaves asel=1 with junk in port bits [7:3]; after return mem_addr holds a
   task automatic set_addr(input logic [10:0] a);
      @(negedge clk); asel = 1'b0; addr_port = a[7:0];
      @(negedge clk); asel = 1'b1; addr_port = {5'b10110, a[10:8]};
      @(negedge clk);
   endtask

   task automatic t_reset_state();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 prog_active", prog_active, 0);
      chk("R1 data_oe", data_oe, 0);
      chk("R1 mem_wr", mem_wr, 0);
      chk("R1 mem_rd", mem_rd, 0);
      rst_n = 1'b1;
   endtask

   task automatic t_short_reset();
      send_entry(23, KEY);
      chk("R2 23 highs do not qualify", prog_active, 0);
   endtask

   task automatic t_enter();
      send_entry(24, KEY);
      chk("R3 key accepted", prog_active, 1);
   endtask

   task automatic t_verify();
      mode = 1'b1;
      set_addr(11'h5A3);
      chk("R5 address assembled, upper port bits ignored", mem_addr, 11'h5A3);
      chk("R6 read request", mem_rd, 1);
      @(negedge clk);
      chk("R6 data_oe", data_oe, 1);
      chk("R6 data_out", data_out, fill(11'h5A3));
      set_addr(11'h0FF);
      @(negedge clk);
      chk("R6 second read", data_out, fill(11'h0FF));
   endtask

   task automatic t_program();
      int w0;
      set_addr(11'h3C1);
      w0 = wr_cnt;
      @(negedge clk); mode = 1'b0; data_in = 8'hE7;
      @(negedge clk);
      chk("R7 strobe", mem_wr, 1);
      chk("R7 strobe address", mem_addr, 11'h3C1);
      chk("R7 strobe data", mem_wdata, 8'hE7);
      chk("R8 oe off in program", data_oe, 0);
      addr_port = 8'h00; data_in = 8'h11;  // moves high half during the strobe
      @(negedge clk);
      chk("R7 strobe one cycle", mem_wr, 0);
      chk("R8 data_out zero", data_out, 0);
      repeat (6) @(negedge clk);
      chk("R7 single write while mode low", wr_cnt - w0, 1);
      chk("R7 target written", mem[11'h3C1], 8'hE7);
      chk("R7 neighbour untouched", mem[11'h0C1], fill(11'h0C1));
      set_addr(11'h3C1);
      mode = 1'b1;
      @(negedge clk);
      chk("R6 read back written byte", data_out, 8'hE7);
   endtask

   task automatic t_glitch_and_exit();
      for (int i = 0; i < 23; i++) begin
         @(negedge clk); rst_pin = 1'b1;
      end
      @(negedge clk); rst_pin = 1'b0;
      @(negedge clk);
      chk("R9 short glitch ignored", prog_active, 1);
      for (int i = 0; i < 24; i++) begin
         @(negedge clk); rst_pin = 1'b1;
      end
      @(negedge clk);
      chk("R9 full reset exits", prog_active, 0);
      rst_pin = 1'b0;
   endtask

   task automatic t_bad_keys();
      int w0;
      send_entry(24, KEY ^ 10'h001);
      chk("R4 first bit wrong", prog_active, 0);
      send_entry(24, KEY ^ 10'h200);
      chk("R4 last bit wrong", prog_active, 0);
      w0 = wr_cnt;
      @(negedge clk); mode = 1'b1; asel = 1'b0; addr_port = 8'h42;
      @(negedge clk);
      chk("R10 no read outside", mem_rd, 0);
      chk("R10 no oe outside", data_oe, 0);
      mode = 1'b0;
      repeat (3) @(negedge clk);
      chk("R10 no write outside", wr_cnt - w0, 0);
      mode = 1'b1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      t_reset_state();
      t_short_reset();
      t_enter();
      t_verify();
      t_program();
      t_glitch_and_exit();
      t_bad_keys();
      t_enter();
      finish_run();
   end
endmodule